// File: doc/BRIEF.md
# Video Sync Period Measurement Unit

This unit times incoming video against the local reference clock. It produces two results: the number of reference-clock cycles in one horizontal period of a chosen source, and the number of horizontal events between two vertical events. A 4-bit select code picks the horizontal source. The choices are sync pulses, data-enable signals, or one of four foreign clocks divided down by a parameterised counter. Each asynchronous input passes through a two-stage synchroniser before its rising edge (or, for the vertical input, the chosen edge) is detected.

A small byte-wide register port controls the unit and returns its results. The unit either runs continuously or performs a single measurement that the host arms. The host can freeze the continuous results while the unit keeps running. For interlaced input, results can be restricted to odd fields. A polling bit flips each time a measurement completes. The result registers load in the same clock cycle as that flip, so the host never reads a mixed pair of values.

Top module: `sync_period_meter`

## Requirements
- R1: After reset, every readable location (addresses 0 to 6) reads 0x00.
- R2: Address 0 is the control byte: bit0 one-shot mode (0 = free-running), bit1 start, bit2 freeze, bit3 vertical falling edge (0 = rising), bit4 free-running enable, bit5 odd-field-only. Bits 7:6 read 0. Address 1 holds the source select in bits 7:4, and bits 3:0 read 0.
- R3: With bit0=0 and bit4=1, the polling bit (address 6 bit0) flips at every vertical event after the first. When it flips, the line-count result (addresses 4/5, low byte first) holds the number of horizontal rising edges from one vertical event up to the next. The clock result (addresses 2/3) holds the reference cycles between the last two horizontal edges of that frame.
- R4: With bit0=1, writing bit1=1 takes exactly one measurement, covering the next vertical event to the one after it. Bit1 reads 0 once that measurement completes. After that the polling bit stays still.
- R5: In free-running mode with freeze set, the polling bit keeps flipping but the results stay unchanged. Clearing freeze lets new results through again.
- R6: Freeze has no effect in one-shot mode.
- R7: Bit3 selects which vertical edge bounds a frame.
- R8: When bit5=1 and the odd-field-present input is high, results and polling-bit flips come only from frames that start while the odd-field input is high. When odd-field-present is low, every frame counts.
- R9: Select codes map to sources as follows: 0 to 6 map to horizontal inputs bit 0 to bit 6, code 9 maps to bit 7, and code 10 maps to bit 8.
- R10: Codes 7, 8, 11 and 12 select divided clock inputs 0, 1, 2 and 3. Each divided clock gives one event per 2*DIV_HALF input-clock cycles.
- R11: Codes 13 to 15 select a constant 0. Both results read 0, and no overflow flag is set.
- R12: The clock result saturates at all ones. Status bit1 is set when a period needed more than all ones cycles. A period of exactly all ones does not set it.
- R13: The line result saturates at all ones. Status bit2 is set when a horizontal edge arrived after the count had reached all ones.
- R14: The results change only in the cycle in which the polling bit flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| hRaw | input | 9 | Asynchronous horizontal sync and data-enable inputs |
| divClkIn | input | 4 | Foreign clocks to be divided and measured |
| vSyncRaw | input | 1 | Asynchronous vertical sync |
| oddFieldRaw | input | 1 | Asynchronous odd-field indicator |
| oddPresentRaw | input | 1 | Asynchronous flag saying the odd-field indicator is valid |

## Verification
The bench sweeps every select code, reserved ones included, and checks the clock period against the arithmetic of its own pulse generator. A mux that swaps two sources would measure the wrong period, and an unblanked reserved code would produce nonzero counts. The saturation boundaries are tested on both sides, so a flag raised one count early, or a counter that wraps, gives a wrong result or a wrong status bit. Frames of unequal length and unequal vertical pulse width separate rising-edge framing from falling-edge framing and odd frames from even frames. A design that ignored the edge select or the field parity would return the other frame length. Freeze is checked in both modes, and the one-shot test confirms that start clears itself and that the polling bit then stays still.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef struct packed {
    logic oddOnly;
    logic runEn;
    logic edgeFall;
    logic freeze;
    logic start;
    logic oneShot;
  } ctrlRegT;

  typedef struct packed {
    logic restart;
    logic capture;
  } strobeT;

  localparam int NUM_SEL = 16;
  localparam int NUM_H_IN = 9;
  localparam int NUM_DIV = 4;
endpackage

// File: rtl/spm_sync.sv
module spm_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spm_div.sv
module spm_div #(
  parameter int DIV_HALF = 500
) (
  input  logic divClk,
  input  logic rstN,
  output logic tog
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge divClk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      tog <= ~tog;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spm_datapath.sv
module spm_datapath
  import spm_pkg::*;
#(
  parameter int CLK_W = 16,
  parameter int LINE_W = 12,
  parameter int DIV_HALF = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_H_IN-1:0] hRaw,
  input  logic [NUM_DIV-1:0]  divClkIn,
  input  logic                vRaw,
  input  logic                oddRaw,
  input  logic                oddPresRaw,
  input  logic [3:0]          hSel,
  input  logic                edgeFall,
  input  strobeT              strobe,
  output logic                vEvt,
  output logic                oddNow,
  output logic                oddPres,
  output logic [CLK_W-1:0]    clkResult,
  output logic [LINE_W-1:0]   lineResult,
  output logic                clkOvfResult,
  output logic                lineOvfResult
);
  localparam int SW = NUM_H_IN + NUM_DIV + 3;

  logic [NUM_DIV-1:0] divTog;
  for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
    spm_div #(.DIV_HALF(DIV_HALF)) u_div (
      .divClk(divClkIn[d]),
      .rstN  (rstN),
      .tog   (divTog[d])
    );
  end

  logic [SW-1:0] syncOut;
  spm_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({oddPresRaw, oddRaw, vRaw, divTog, hRaw}),
    .dout(syncOut)
  );

  logic [NUM_H_IN-1:0] hS;
  logic [NUM_DIV-1:0]  divS;
  logic                vS;
  assign hS      = syncOut[NUM_H_IN-1:0];
  assign divS    = syncOut[NUM_H_IN +: NUM_DIV];
  assign vS      = syncOut[NUM_H_IN + NUM_DIV];
  assign oddNow  = syncOut[NUM_H_IN + NUM_DIV + 1];
  assign oddPres = syncOut[NUM_H_IN + NUM_DIV + 2];

  logic [NUM_SEL-1:0] srcVec;
  for (genvar c = 0; c < NUM_SEL; c++) begin : g_src
    if (c <= 6) begin : g_direct
      assign srcVec[c] = hS[c];
    end else if (c == 7) begin : g_d0
      assign srcVec[c] = divS[0];
    end else if (c == 8) begin : g_d1
      assign srcVec[c] = divS[1];
    end else if (c == 9) begin : g_t0
      assign srcVec[c] = hS[7];
    end else if (c == 10) begin : g_t1
      assign srcVec[c] = hS[8];
    end else if (c == 11) begin : g_d2
      assign srcVec[c] = divS[2];
    end else if (c == 12) begin : g_d3
      assign srcVec[c] = divS[3];
    end else begin : g_rsv
      assign srcVec[c] = 1'b0;
    end
  end

  logic hSrc, hPrev, vPrev, hEvt;
  assign hSrc = srcVec[hSel];
  assign hEvt = hSrc & ~hPrev;
  assign vEvt = edgeFall ? (~vS & vPrev) : (vS & ~vPrev);

  logic [CLK_W-1:0]  clkCnt, lastPeriod;
  logic              clkSat, lastOvf;
  logic [LINE_W-1:0] lineCnt;
  logic              lineOvf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev <= 1'b0;
      vPrev <= 1'b0;
    end else begin
      hPrev <= hSrc;
      vPrev <= vS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkCnt     <= '0;
      clkSat     <= 1'b0;
      lastPeriod <= '0;
      lastOvf    <= 1'b0;
    end else begin
      if (hEvt) begin
        clkCnt <= CLK_W'(1);
        clkSat <= 1'b0;
      end else if (clkCnt == '1) begin
        clkSat <= 1'b1;
      end else begin
        clkCnt <= clkCnt + 1'b1;
      end
      if (hEvt) begin
        lastPeriod <= clkCnt;
        lastOvf    <= clkSat;
      end else if (strobe.restart) begin
        lastPeriod <= '0;
        lastOvf    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt <= '0;
      lineOvf <= 1'b0;
    end else if (strobe.restart) begin
      lineCnt <= LINE_W'(hEvt);
      lineOvf <= 1'b0;
    end else if (hEvt) begin
      if (lineCnt == '1) lineOvf <= 1'b1;
      else lineCnt <= lineCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkResult     <= '0;
      lineResult    <= '0;
      clkOvfResult  <= 1'b0;
      lineOvfResult <= 1'b0;
    end else if (strobe.capture) begin
      clkResult     <= lastPeriod;
      lineResult    <= lineCnt;
      clkOvfResult  <= lastOvf;
      lineOvfResult <= lineOvf;
    end
  end

  AST_CLK_SAT_AT_ONES: assert property (@(posedge clk) disable iff (!rstN)
    clkOvfResult |-> (clkResult == '1)); // R12
  AST_LINE_SAT_AT_ONES: assert property (@(posedge clk) disable iff (!rstN)
    lineOvfResult |-> (lineResult == '1)); // R13
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  input  logic       vEvt,
  input  logic       oddNow,
  input  logic       oddPres,
  output ctrlRegT    ctrlReg,
  output logic [3:0] hSel,
  output logic       poll,
  output strobeT     strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_MEAS} stateT;
  stateT state;
  logic  frameOdd, active, skipFrame, done;

  always_comb begin
    active    = ctrlReg.oneShot ? ctrlReg.start : ctrlReg.runEn;
    skipFrame = ctrlReg.oddOnly && oddPres && !frameOdd;
    done      = (state == ST_MEAS) && active && vEvt && !skipFrame;
    strobe.restart = active && vEvt && (state != ST_IDLE);
    strobe.capture = done && (ctrlReg.oneShot || !ctrlReg.freeze);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (active) state <= ST_ARM;
        ST_ARM: begin
          if (!active) state <= ST_IDLE;
          else if (vEvt) state <= ST_MEAS;
        end
        ST_MEAS: begin
          if (!active) state <= ST_IDLE;
          else if (done && ctrlReg.oneShot) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameOdd <= 1'b0;
      poll     <= 1'b0;
    end else begin
      if (strobe.restart) frameOdd <= oddNow;
      if (done) poll <= ~poll;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      hSel    <= '0;
    end else begin
      if (regWe && regAddr == 3'd0) ctrlReg <= ctrlRegT'(regWdata[5:0]);
      else if (done && ctrlReg.oneShot) ctrlReg.start <= 1'b0;
      if (regWe && regAddr == 3'd1) hSel <= regWdata[7:4];
    end
  end

  AST_POLL_FOLLOWS_VEVT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(poll) |-> $past(vEvt)); // R3
  AST_START_CLEARS_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ctrlReg.start) && !$past(regWe && regAddr == 3'd0)) |-> (poll != $past(poll))); // R4
endmodule

// File: rtl/sync_period_meter.sv
module sync_period_meter
  import spm_pkg::*;
#(
  parameter int CLK_W = 16,
  parameter int LINE_W = 12,
  parameter int DIV_HALF = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic [8:0] hRaw,
  input  logic [3:0] divClkIn,
  input  logic       vSyncRaw,
  input  logic       oddFieldRaw,
  input  logic       oddPresentRaw
);
  ctrlRegT             ctrlReg;
  strobeT              strobe;
  logic [3:0]          hSel;
  logic                poll, vEvt, oddNow, oddPres;
  logic [CLK_W-1:0]    clkResult;
  logic [LINE_W-1:0]   lineResult;
  logic                clkOvf, lineOvf;

  spm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .vEvt(vEvt), .oddNow(oddNow), .oddPres(oddPres),
    .ctrlReg(ctrlReg), .hSel(hSel), .poll(poll), .strobe(strobe)
  );

  spm_datapath #(
    .CLK_W(CLK_W), .LINE_W(LINE_W), .DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hRaw(hRaw), .divClkIn(divClkIn), .vRaw(vSyncRaw),
    .oddRaw(oddFieldRaw), .oddPresRaw(oddPresentRaw), .hSel(hSel),
    .edgeFall(ctrlReg.edgeFall), .strobe(strobe), .vEvt(vEvt), .oddNow(oddNow),
    .oddPres(oddPres), .clkResult(clkResult), .lineResult(lineResult),
    .clkOvfResult(clkOvf), .lineOvfResult(lineOvf)
  );

  logic [15:0] clkWide, lineWide;
  always_comb begin
    clkWide = '0;
    clkWide[CLK_W-1:0] = clkResult;
    lineWide = '0;
    lineWide[LINE_W-1:0] = lineResult;
    unique case (regAddr)
      3'd0: regRdata = {2'b00, ctrlReg};
      3'd1: regRdata = {hSel, 4'h0};
      3'd2: regRdata = clkWide[7:0];
      3'd3: regRdata = clkWide[15:8];
      3'd4: regRdata = lineWide[7:0];
      3'd5: regRdata = lineWide[15:8];
      3'd6: regRdata = {5'b0, lineOvf, clkOvf, poll};
      default: regRdata = 8'h00;
    endcase
  end

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg.oneShot && ctrlReg.freeze) |=> ($stable(clkResult) && $stable(lineResult))); // R5
  AST_RESULT_WITH_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(clkResult) || !$stable(lineResult)) |-> !$stable(poll)); // R14
endmodule

// File: tb/sync_period_meter_bench.sv
module sync_period_meter_bench;
  localparam int CW = 8;
  localparam int LW = 4;
  localparam int DH = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [8:0] hRaw;
  logic divClk = 1'b0;
  logic vSyncRaw, oddFieldRaw;
  logic oddPresentRaw = 1'b0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;
  initial begin
    #2;
    forever #8 divClk = ~divClk;
  end

  sync_period_meter #(.CLK_W(CW), .LINE_W(LW), .DIV_HALF(DH)) u_sync_period_meter (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .hRaw(hRaw), .divClkIn({4{divClk}}), .vSyncRaw(vSyncRaw),
    .oddFieldRaw(oddFieldRaw), .oddPresentRaw(oddPresentRaw)
  );

  // Pulse generator: frames of lenOdd/lenEven lines, vertical pulse offset by half a line
  int hPer = 8, lenOdd = 6, lenEven = 6, hiOdd = 1, hiEven = 1;
  int hCnt = 0, line = 0, frame = 0;
  logic [8:0] mask = '0;
  always @(negedge clk) begin
    if (hCnt >= hPer - 1) begin
      hCnt = 0;
      if (line >= ((frame % 2 == 1) ? lenOdd : lenEven) - 1) begin
        line = 0;
        frame = frame + 1;
      end else line = line + 1;
    end else hCnt = hCnt + 1;
  end
  int vPos, hiCur;
  always_comb begin
    hiCur = (frame % 2 == 1) ? hiOdd : hiEven;
    vPos = line * hPer + hCnt;
    vSyncRaw = (vPos >= hPer / 2) && (vPos < hiCur * hPer + hPer / 2);
    oddFieldRaw = (frame % 2 == 1);
    hRaw = (hCnt < 2) ? mask : 9'b0;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitPoll(input string tag);
    logic [7:0] s0, s1;
    rd(3'd6, s0);
    for (int i = 0; i < 20000; i++) begin
      rd(3'd6, s1);
      if (s1[0] != s0[0]) return;
    end
    check({tag, " poll toggle timeout"}, 0, 1);
  endtask

  task automatic measure(input string tag, output int c, output int l, output logic [7:0] st);
    logic [7:0] b0, b1;
    waitPoll(tag); waitPoll(tag); waitPoll(tag);
    rd(3'd2, b0); rd(3'd3, b1); c = {b1, b0};
    rd(3'd4, b0); rd(3'd5, b1); l = {b1, b0};
    rd(3'd6, st);
  endtask

  task automatic setGen(input int p, input int lo, input int le, input int ho, input int he,
                        input logic [8:0] m);
    @(posedge clk);
    hPer = p; lenOdd = lo; lenEven = le; hiOdd = ho; hiEven = he; mask = m;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(8 * 190000);
    $display("FAIL watchdog expired actual=running expected=done");
    checks++; fails++;
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d, s0;
    int c, l, expC, m2, codeBit;
    logic [7:0] st;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reset addr %0d", a), d, 0);
    end

    // R2: reserved bits read zero
    wr(3'd0, 8'hFF); rd(3'd0, d); check("R2 ctrl readback", d, 8'h3F);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R2 select readback", d, 8'hF0);
    wr(3'd1, 8'h00);

    // R3: free-running basic patterns
    wr(3'd0, 8'h10);
    setGen(37, 9, 9, 1, 1, 9'h001);
    measure("R3", c, l, st);
    check("R3 clocks per line P=37", c, 37); check("R3 lines per frame N=9", l, 9);
    setGen(12, 4, 4, 1, 1, 9'h001);
    measure("R3", c, l, st);
    check("R3 clocks per line P=12", c, 12); check("R3 lines per frame N=4", l, 4);

    // R9 R10 R11: sweep every select code
    for (int code = 0; code < 16; code++) begin
      wr(3'd1, 8'(code << 4));
      if (code <= 6 || code == 9 || code == 10) begin
        codeBit = (code <= 6) ? code : code - 2;
        setGen(6 + code, 5, 5, 1, 1, 9'(1 << codeBit));
        measure("R9", c, l, st);
        check($sformatf("R9 code %0d clocks", code), c, 6 + code);
        check($sformatf("R9 code %0d lines", code), l, 5);
      end else if (code <= 12) begin
        expC = 2 * DH * 2;
        setGen(expC, 5, 5, 1, 1, 9'h000);
        measure("R10", c, l, st);
        check($sformatf("R10 code %0d divided clocks", code), c, expC);
        check($sformatf("R10 code %0d lines", code), l, 5);
      end else begin
        setGen(10, 5, 5, 1, 1, 9'h1FF);
        measure("R11", c, l, st);
        check($sformatf("R11 code %0d clocks", code), c, 0);
        check($sformatf("R11 code %0d lines", code), l, 0);
        check($sformatf("R11 code %0d ovf", code), st[2:1], 0);
      end
    end
    wr(3'd1, 8'h00);

    // R12: clock saturation boundary
    setGen(255, 3, 3, 1, 1, 9'h001);
    measure("R12", c, l, st);
    check("R12 exact max period", c, 255); check("R12 no ovf at max", st[1], 0);
    setGen(300, 3, 3, 1, 1, 9'h001);
    measure("R12", c, l, st);
    check("R12 saturated period", c, 255); check("R12 ovf flag", st[1], 1);

    // R13: line saturation boundary
    setGen(6, 15, 15, 1, 1, 9'h001);
    measure("R13", c, l, st);
    check("R13 exact max lines", l, 15); check("R13 no ovf at max", st[2], 0);
    setGen(6, 20, 20, 1, 1, 9'h001);
    measure("R13", c, l, st);
    check("R13 saturated lines", l, 15); check("R13 ovf flag", st[2], 1);

    // R5: freeze keeps toggling, holds results
    setGen(9, 6, 6, 1, 1, 9'h001);
    measure("R5", c, l, st);
    check("R5 pre-freeze clocks", c, 9);
    wr(3'd0, 8'h14);
    setGen(13, 6, 6, 1, 1, 9'h001);
    measure("R5", c, l, st);
    check("R5 frozen clocks", c, 9); check("R5 frozen lines", l, 6);
    wr(3'd0, 8'h10);
    measure("R5", c, l, st);
    check("R5 unfrozen clocks", c, 13);

    // R8 R7: unequal frames, odd-only and edge select
    setGen(8, 7, 11, 2, 5, 9'h001);
    oddPresentRaw = 1'b1;
    wr(3'd0, 8'h30);
    measure("R8", c, l, st);
    check("R8 odd-only rising lines", l, 7);
    wr(3'd0, 8'h38);
    measure("R7", c, l, st);
    check("R7 odd-only falling lines", l, 10);
    oddPresentRaw = 1'b0;
    wr(3'd0, 8'h30);
    measure("R8", c, l, st);
    waitPoll("R8"); rd(3'd4, d); m2 = d;
    check("R8 no odd signal: both frame lengths seen", l + m2, 18);
    wr(3'd0, 8'h00);

    // R4: one-shot
    setGen(10, 5, 5, 1, 1, 9'h001);
    repeat (100) @(negedge clk);
    rd(3'd6, s0);
    wr(3'd0, 8'h03);
    for (int i = 0; i < 5000; i++) begin
      rd(3'd0, d);
      if (d[1] == 1'b0) break;
    end
    check("R4 start self-clears", d[1], 0);
    rd(3'd6, st); check("R4 poll toggled once", st[0], !s0[0]);
    rd(3'd2, d); check("R4 one-shot clocks", d, 10);
    rd(3'd4, d); check("R4 one-shot lines", d, 5);
    repeat (300) @(negedge clk);
    rd(3'd6, d); check("R4 no further toggles", d[0], st[0]);

    // R6: freeze ignored in one-shot
    setGen(12, 5, 5, 1, 1, 9'h001);
    repeat (100) @(negedge clk);
    wr(3'd0, 8'h07);
    for (int i = 0; i < 5000; i++) begin
      rd(3'd0, d);
      if (d[1] == 1'b0) break;
    end
    rd(3'd2, d); check("R6 one-shot with freeze updates", d, 12);

    summary();
    $finish;
  end
endmodule